// File: doc/BRIEF.md
# Polling Receiver Power Sequencer

This block decides when the signal path of a low-power radio receiver is powered. Most of the time the path is off and the block sits in a sleep phase, counting prescaled clock ticks. When the sleep time is over it powers the path and waits a fixed settling period. It then hands control to an external validity checker. If the checker confirms a transmitter, the block moves to receiving and opens a gate that forwards demodulated data to the host. If the checker rejects the signal, the block returns to sleep.

The host can hold the receiver asleep through an enable input. A temporary-extension flag multiplies the sleep time by a programmable factor. The flag stays set only while the checks keep passing and drops on the first rejection. A programmed sleep time of zero lets a host that drives the enable input get a response at once instead of waiting for periodic polling.

States: SLEEP (mode 0), STARTUP (mode 1), CHECK (mode 2), RECEIVE (mode 3). Transitions:
- SLEEP_DONE: SLEEP to STARTUP.
- SETTLED: STARTUP to CHECK.
- CONFIRM: CHECK to RECEIVE.
- REJECT: CHECK to SLEEP.
- RELEASE: RECEIVE to SLEEP.

Top module: `poll_seq`

## Requirements
- R1: After reset, mode is 0 (SLEEP), and path_en and data_gate are both low.
- R2: mode encodes the state as SLEEP=0, STARTUP=1, CHECK=2, RECEIVE=3. path_en is high in modes 1, 2 and 3. data_gate is high only in mode 3.
- R3: With the extension flag clear and en_pin high, SLEEP lasts exactly sleep_val tick cycles. The state changes to STARTUP on the clock edge that samples the last of those ticks.
- R4: STARTUP lasts exactly STARTUP_TICKS tick cycles, then the state changes to CHECK. chk_pass and chk_fail have no effect during STARTUP.
- R5: In CHECK, chk_pass alone leads to RECEIVE on the next edge. chk_fail leads to SLEEP on the next edge, even when chk_pass is high at the same time. With neither input high, the state stays in CHECK.
- R6: A pulse on ext_req sets the extension flag. While the flag is set, SLEEP lasts sleep_val*ext_factor tick cycles. The flag stays set through CHECK cycles that pass.
- R7: chk_fail in CHECK clears the extension flag, and a clear wins over a request in the same cycle. The next SLEEP lasts sleep_val ticks.
- R8: While en_pin is low, the state stays in SLEEP and the sleep count restarts from zero. Ticks seen while en_pin is low do not count.
- R9: With sleep_val equal to 0, SLEEP leaves for STARTUP on the first edge at which en_pin is high, without waiting for a tick.
- R10: In RECEIVE, host_off or sig_lost returns the state to SLEEP on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled clock enable for the timers |
| chk_pass | input | 1 | Validity checker reports a valid signal |
| chk_fail | input | 1 | Validity checker reports an invalid signal |
| en_pin | input | 1 | Host enable; low holds the receiver asleep |
| sleep_val | input | SLP_W | Programmed sleep time in ticks |
| ext_factor | input | EXT_W | Multiplier applied while the extension flag is set |
| ext_req | input | 1 | Pulse that sets the temporary-extension flag |
| host_off | input | 1 | Host command to leave receiving |
| sig_lost | input | 1 | Validity-loss indication during receiving |
| path_en | output | 1 | Signal-path power enable |
| mode | output | 2 | Current state code |
| data_gate | output | 1 | Passes demodulated data to the host |

## Verification
The bench measures how many ticks each mode occupies and compares each measurement with a queue of expected segments. It first uses a plain polling cycle that the checker rejects, then one that the checker confirms. Comparing the extended cycle with the cycle that follows the first rejection separates a working self-clearing flag from a flag that sticks or is never applied. Holding chk_fail high through STARTUP, and driving pass and fail together in CHECK, separate a result that is ignored in the right state from one that leaks through, and show which result has priority. Dropping en_pin part way through a sleep, and programming a zero sleep time, show that the timer restarts from zero and that the immediate-response path needs no tick.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        PS_SLEEP   = 2'd0,
        PS_STARTUP = 2'd1,
        PS_CHECK   = 2'd2,
        PS_RECEIVE = 2'd3
    } poll_state_t;
endpackage

// File: rtl/poll_tick_timer.sv
module poll_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = tick && !clr && (limit != '0) && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || done)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/poll_ext_flag.sv
module poll_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // A clear has priority over a set in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (clr_req)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
    end
endmodule

// File: rtl/poll_seq.sv
module poll_seq
    import poll_pkg::*;
#(
    parameter int SLP_W         = 8,
    parameter int EXT_W         = 4,
    parameter int STARTUP_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             chk_pass,
    input  logic             chk_fail,
    input  logic             en_pin,
    input  logic [SLP_W-1:0] sleep_val,
    input  logic [EXT_W-1:0] ext_factor,
    input  logic             ext_req,
    input  logic             host_off,
    input  logic             sig_lost,
    output logic             path_en,
    output logic [1:0]       mode,
    output logic             data_gate
);
    localparam int TGT_W = SLP_W + EXT_W;
    localparam int ST_W  = $clog2(STARTUP_TICKS + 1);

    poll_state_t state_q, state_d;
    logic             ext_flag;
    logic             slp_clr, slp_done, st_clr, st_done, ext_clr;
    logic [TGT_W-1:0] slp_target;
    logic             slp_zero;

    assign slp_target = ext_flag ? (TGT_W'(sleep_val) * TGT_W'(ext_factor))
                                 : TGT_W'(sleep_val);
    assign slp_zero   = (slp_target == '0);
    assign slp_clr    = (state_q != PS_SLEEP) || !en_pin;
    assign st_clr     = (state_q != PS_STARTUP);
    assign ext_clr    = (state_q == PS_CHECK) && chk_fail;

    poll_tick_timer #(.CW(TGT_W)) u_sleep_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (slp_clr),
        .tick  (tick),
        .limit (slp_target),
        .done  (slp_done)
    );

    poll_tick_timer #(.CW(ST_W)) u_start_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_clr),
        .tick  (tick),
        .limit (ST_W'(STARTUP_TICKS)),
        .done  (st_done)
    );

    poll_ext_flag u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (ext_req),
        .clr_req (ext_clr),
        .flag    (ext_flag)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_SLEEP:   if (en_pin && (slp_zero || slp_done)) state_d = PS_STARTUP;
            PS_STARTUP: if (st_done)                          state_d = PS_CHECK;
            PS_CHECK: begin
                if (chk_fail)      state_d = PS_SLEEP;
                else if (chk_pass) state_d = PS_RECEIVE;
            end
            PS_RECEIVE: if (host_off || sig_lost)             state_d = PS_SLEEP;
            default:                                          state_d = PS_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PS_SLEEP;
        else
            state_q <= state_d;
    end

    always_comb begin
        mode      = state_q;
        path_en   = 1'b0;
        data_gate = 1'b0;
        unique case (state_q)
            PS_SLEEP:   ;
            PS_STARTUP: path_en = 1'b1;
            PS_CHECK:   path_en = 1'b1;
            PS_RECEIVE: begin
                path_en   = 1'b1;
                data_gate = 1'b1;
            end
            default:    ;
        endcase
    end

    a_r4_startup_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STARTUP && !st_done) |=> (state_q == PS_STARTUP));
    a_r5_pass_confirms: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_CHECK && chk_pass && !chk_fail) |=> (state_q == PS_RECEIVE));
    a_r5_fail_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_CHECK && chk_fail) |=> (state_q == PS_SLEEP));
    a_r7_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_CHECK && chk_fail) |=> !ext_flag);
    a_r8_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SLEEP && !en_pin) |=> (state_q == PS_SLEEP));
    a_r9_zero_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SLEEP && en_pin && sleep_val == '0) |=> (state_q == PS_STARTUP));
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RECEIVE && (host_off || sig_lost)) |=> (state_q == PS_SLEEP));
endmodule

// File: tb/poll_seq_bench.sv
module poll_seq_bench;
    localparam int ST = 4;
    localparam int DC = -1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, chk_pass = 1'b0, chk_fail = 1'b0, en_pin = 1'b1;
    logic [7:0] sleep_val = 8'd3;
    logic [3:0] ext_factor = 4'd3;
    logic ext_req = 1'b0, host_off = 1'b0, sig_lost = 1'b0;
    logic path_en, data_gate;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int q_mode[$];
    int q_ticks[$];
    string q_req[$];

    always #10 clk = ~clk;

    poll_seq #(.SLP_W(8), .EXT_W(4), .STARTUP_TICKS(ST)) u_poll_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chk_pass(chk_pass),
        .chk_fail(chk_fail), .en_pin(en_pin), .sleep_val(sleep_val),
        .ext_factor(ext_factor), .ext_req(ext_req), .host_off(host_off),
        .sig_lost(sig_lost), .path_en(path_en), .mode(mode), .data_gate(data_gate)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_seg(input int m, input int t, input string req);
        q_mode.push_back(m);
        q_ticks.push_back(t);
        q_req.push_back(req);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_mode(input int m, input string req);
        for (int i = 0; i < 3000; i++) begin
            if (int'(mode) == m) return;
            step();
        end
        check(1'b0, req, int'(mode), m);
    endtask

    // Tick generator: one tick every third cycle
    initial begin
        int ph;
        ph = 0;
        forever begin
            step();
            tick = (ph == 2);
            ph = (ph == 2) ? 0 : ph + 1;
        end
    end

    // Monitor: measures each mode segment in ticks and compares with the queue
    initial begin
        int prev, cnt, em, et;
        string er;
        prev = 0;
        cnt = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (int'(mode) != prev) begin
                if (q_mode.size() == 0) begin
                    check(1'b0, "R2 unexpected transition", int'(mode), prev);
                end else begin
                    em = q_mode.pop_front();
                    et = q_ticks.pop_front();
                    er = q_req.pop_front();
                    check(em == prev, er, prev, em);
                    if (et != DC) check(et == cnt, er, cnt, et);
                end
                prev = int'(mode);
                cnt = 0;
            end
            if (mode == 2'd0 && !en_pin) cnt = 0;
            else if (tick) cnt++;
            check(path_en == (mode != 2'd0), "R2 path_en", int'(path_en), int'(mode != 2'd0));
            check(data_gate == (mode == 2'd3), "R2 data_gate", int'(data_gate), int'(mode == 2'd3));
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode == 2'd0, "R1 mode", int'(mode), 0);
        check(!path_en, "R1 path_en", int'(path_en), 0);
        check(!data_gate, "R1 data_gate", int'(data_gate), 0);

        // Plain cycle, rejected: R3, R4, R5
        expect_seg(0, 3, "R3");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        wait_mode(2, "R5");
        chk_fail = 1'b1; step(); chk_fail = 1'b0;

        // Confirmed cycle, host_off release: R5, R10
        expect_seg(0, 3, "R3");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        expect_seg(3, DC, "R10");
        wait_mode(2, "R5");
        chk_pass = 1'b1; step(); chk_pass = 1'b0;
        wait_mode(3, "R5");
        ext_req = 1'b1; step(); ext_req = 1'b0;
        step();
        host_off = 1'b1; step(); host_off = 1'b0;

        // Extended sleep while checks pass: R6, sig_lost release R10
        expect_seg(0, 9, "R6");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        expect_seg(3, DC, "R10");
        wait_mode(2, "R6");
        chk_pass = 1'b1; step(); chk_pass = 1'b0;
        wait_mode(3, "R6");
        sig_lost = 1'b1; step(); sig_lost = 1'b0;
        expect_seg(0, 9, "R6");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        wait_mode(2, "R6");
        chk_fail = 1'b1; step(); chk_fail = 1'b0;

        // Flag cleared -> regular sleep R7; enable low holds sleep R8
        expect_seg(0, 3, "R7");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        en_pin = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step();
            check(mode == 2'd0, "R8 held in sleep", int'(mode), 0);
        end
        en_pin = 1'b1;
        wait_mode(2, "R7");
        // Pass and fail together: fail wins (R5)
        chk_pass = 1'b1; chk_fail = 1'b1; step();
        chk_pass = 1'b0; chk_fail = 1'b0;
        check(mode == 2'd0, "R5 fail priority", int'(mode), 0);

        // Results ignored during startup: R4
        expect_seg(0, 3, "R3");
        expect_seg(1, ST, "R4 ignore");
        expect_seg(2, DC, "R4 ignore");
        expect_seg(3, DC, "R10");
        wait_mode(1, "R4");
        chk_fail = 1'b1;
        wait_mode(2, "R4");
        chk_fail = 1'b0; chk_pass = 1'b1; step(); chk_pass = 1'b0;
        check(mode == 2'd3, "R4 then R5 confirm", int'(mode), 3);

        // Zero sleep, host-driven: R9
        expect_seg(0, DC, "R9");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        en_pin = 1'b0;
        sleep_val = 8'd0;
        host_off = 1'b1; step(); host_off = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            check(mode == 2'd0, "R8 zero sleep held", int'(mode), 0);
        end
        en_pin = 1'b1;
        step();
        check(mode == 2'd1, "R9 immediate start", int'(mode), 1);
        wait_mode(2, "R9");
        expect_seg(0, DC, "R9");
        expect_seg(1, ST, "R4");
        expect_seg(2, DC, "R5");
        chk_fail = 1'b1; step(); chk_fail = 1'b0;
        en_pin = 1'b0;
        check(mode == 2'd0, "R9 rejected", int'(mode), 0);
        step();
        en_pin = 1'b1;
        step();
        check(mode == 2'd1, "R9 immediate restart", int'(mode), 1);
        wait_mode(2, "R9");
        en_pin = 1'b0;
        chk_fail = 1'b1; step(); chk_fail = 1'b0;
        repeat (10) step();
        check(q_mode.size() == 0, "R2 segments left", q_mode.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule